// File: doc/BRIEF.md
# Clock Output Mode Controller

This block decides, cycle by cycle, whether the PLLs and each clock output of a multi-output clock generator are running. It watches two multifunction pins. The first pin works in one of two ways, chosen by a configuration bit. It can be an active-low power-down request that stops everything. It can also be an output enable that gates only the outputs marked as sensitive to it. The second pin is an active-high reset. A second configuration bit picks what that reset does. It either requests a reload of all default register values, or it holds every output low while the programmed settings stay in place. In the second case, all outputs then restart on one common cycle.

Both pins pass through a synchronizer before they are decoded. Every control output leaves the block from a register. A keep-alive bit decides what happens to the volatile configuration during power-down: it is either kept, which the block signals with a retain flag, or dropped, which the block signals with a restore request to the register file. After a clean-start release, a programmable lock-delay count lets the PLLs settle before any output is released.

Top module: `clk_mode_ctrl`

## Requirements
- R1: While `rst_n` is low: `pll_en` = 0, every `out_en` bit = 0, every `out_force_low` bit = 1, `cfg_restore` = 0 and `regs_retain` = 0.
- R2: Both pins are synchronized through two flops, and the output register adds one more. A pin change made between two rising edges reaches the outputs on the third following rising edge and leaves them unchanged after the second.
- R3: With `cfg_pin_is_oe` = 0, a low level on `pd_oe_pin` drives `pll_en` = 0 and every `out_en` bit = 0.
- R4: During power-down with `cfg_keep_alive` = 1: `regs_retain` = 1 and `cfg_restore` = 0.
- R5: During power-down with `cfg_keep_alive` = 0: `cfg_restore` = 1 and `regs_retain` = 0. Once the pin returns high, both flags are 0 and all outputs and the PLLs run again.
- R6: With `cfg_pin_is_oe` = 1 and the pin low, `out_en[i]` = 0 exactly for the outputs with `cfg_oe_sens[i]` = 1. The other outputs stay enabled, `pll_en` stays 1, and neither flag is raised.
- R7: With `cfg_pin_is_oe` = 1 and the pin high, every output is enabled, whatever `cfg_oe_sens` holds.
- R8: With `cfg_clean_start` = 0 and `rst_pin` high: `cfg_restore` = 1, `pll_en` = 0 and all outputs are off. Three rising edges after the pin falls, normal operation returns.
- R9: With `cfg_clean_start` = 1 and `rst_pin` high: all outputs are off, while `pll_en` stays 1 and `cfg_restore` stays 0.
- R10: After a clean-start reset pin falls, with lock delay D = `cfg_lock_dly`, all outputs stay off through D+4 rising edges. They all turn on together at rising edge D+5.
- R11: `out_force_low[i]` is always the inverse of `out_en[i]`.
- R12: If the reset pin rises again during the clean-start lock wait, the outputs stay off, and the next release starts a full D+5 count anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pd_oe_pin | input | 1 | Raw multifunction pin: power-down (low active) or output enable (high enables) |
| rst_pin | input | 1 | Raw active-high reset pin |
| cfg_pin_is_oe | input | 1 | 1: pin is output enable; 0: pin is power-down |
| cfg_keep_alive | input | 1 | 1: keep volatile registers during power-down |
| cfg_clean_start | input | 1 | 1: clean-start reset style; 0: full default restore |
| cfg_oe_sens | input | N_OUT | Per-output sensitivity to the output-enable pin |
| cfg_lock_dly | input | DLY_W | Lock-delay cycles after a clean-start release |
| pll_en | output | 1 | PLLs enabled |
| out_en | output | N_OUT | Per-output enable |
| out_force_low | output | N_OUT | Per-output force-low (driven low, not floating) |
| cfg_restore | output | 1 | Request to reload default register values |
| regs_retain | output | 1 | Volatile registers held while powered down |

## Verification
The hardest state to reach is the clean-start sequencer in its lock-wait phase when the reset pin comes back. The bench releases the pin, lets a known number of edges go by so the count has partly run, and raises the pin again. It then waits past the point where the old count would have ended and checks that the outputs are still off. The exact release edge is also checked, for a zero delay and for a non-zero delay: the outputs must be off one edge before the expected edge and all on at that edge.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_HOLD = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;
endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
   parameter int          WIDTH     = 2,
   parameter int          STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cmc_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= RESET_VAL;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cmc_pin_decode.sv
module cmc_pin_decode #(
   parameter int N_OUT = 8
) (
   input  logic             pd_oe_s,
   input  logic             rst_s,
   input  logic             cfg_pin_is_oe,
   input  logic             cfg_clean_start,
   input  logic [N_OUT-1:0] cfg_oe_sens,
   output logic             pd_active,
   output logic             full_rst,
   output logic             clean_rst,
   output logic [N_OUT-1:0] oe_block
);
   always_comb begin
      pd_active = !cfg_pin_is_oe && !pd_oe_s;
      full_rst  = rst_s && !cfg_clean_start;
      clean_rst = rst_s && cfg_clean_start;
      oe_block  = (cfg_pin_is_oe && !pd_oe_s) ? cfg_oe_sens : '0;
   end
endmodule

// File: rtl/cmc_restart_seq.sv
module cmc_restart_seq
   import cmc_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clean_en,
   input  logic             clean_rst,
   input  logic [DLY_W-1:0] lock_dly,
   output logic             hold
);
   seq_state_e       state;
   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else if (!clean_en) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            SEQ_IDLE: if (clean_rst) state <= SEQ_HOLD;
            SEQ_HOLD: if (!clean_rst) begin
               state <= SEQ_WAIT;
               cnt   <= lock_dly;
            end
            SEQ_WAIT: begin
               if (clean_rst)       state <= SEQ_HOLD;
               else if (cnt == '0)  state <= SEQ_IDLE;
               else                 cnt   <= cnt - 1'b1;
            end
            default:  state <= SEQ_IDLE;
         endcase
      end
   end

   assign hold = clean_en && (clean_rst || state != SEQ_IDLE);

   // R10: a running lock count is not cut short
   a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_en && state == SEQ_WAIT && !clean_rst && cnt != '0) |=> state == SEQ_WAIT);
   // R12: reset returning during the wait goes back to hold
   a_r12_rehold: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_en && state == SEQ_WAIT && clean_rst) |=> state == SEQ_HOLD);
endmodule

// File: rtl/cmc_out_stage.sv
module cmc_out_stage #(
   parameter int N_OUT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_active,
   input  logic             full_rst,
   input  logic             hold,
   input  logic             keep_alive,
   input  logic [N_OUT-1:0] oe_block,
   output logic             pll_en,
   output logic [N_OUT-1:0] out_en,
   output logic [N_OUT-1:0] out_force_low,
   output logic             cfg_restore,
   output logic             regs_retain
);
   logic kill_all;
   assign kill_all = pd_active || full_rst || hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_en      <= 1'b0;
         cfg_restore <= 1'b0;
         regs_retain <= 1'b0;
      end else begin
         pll_en      <= !(pd_active || full_rst);
         cfg_restore <= full_rst || (pd_active && !keep_alive);
         regs_retain <= pd_active && keep_alive && !full_rst;
      end
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_en[i]        <= 1'b0;
            out_force_low[i] <= 1'b1;
         end else begin
            out_en[i]        <= !(kill_all || oe_block[i]);
            out_force_low[i] <= kill_all || oe_block[i];
         end
      end

      // R6: a sensitive output is gated by the enable pin
      a_r6_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
         oe_block[i] |=> !out_en[i]);
   end

   // R3: power-down stops PLLs and all outputs
   a_r3_pd_off: assert property (@(posedge clk) disable iff (!rst_n)
      pd_active |=> (!pll_en && out_en == '0));
   // R4: keep-alive power-down retains registers
   a_r4_retain: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_active && keep_alive && !full_rst) |=> (regs_retain && !cfg_restore));
   // R8: full-restore reset requests defaults
   a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
      full_rst |=> (cfg_restore && !pll_en && out_en == '0));
   // R9: clean-start hold keeps every output off
   a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> out_en == '0);
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
   parameter int N_OUT       = 8,
   parameter int DLY_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_oe_pin,
   input  logic             rst_pin,
   input  logic             cfg_pin_is_oe,
   input  logic             cfg_keep_alive,
   input  logic             cfg_clean_start,
   input  logic [N_OUT-1:0] cfg_oe_sens,
   input  logic [DLY_W-1:0] cfg_lock_dly,
   output logic             pll_en,
   output logic [N_OUT-1:0] out_en,
   output logic [N_OUT-1:0] out_force_low,
   output logic             cfg_restore,
   output logic             regs_retain
);
   localparam int PIN_W = 2;
   localparam logic [PIN_W-1:0] PIN_IDLE = 2'b01; // {rst inactive, pd pin high}

   generate
      if (N_OUT < 1 || N_OUT > 64) begin : g_bad_nout
         $error("clk_mode_ctrl: N_OUT out of range");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("clk_mode_ctrl: DLY_W must be positive");
      end
   endgenerate

   logic [PIN_W-1:0] pins_s;
   logic             pd_active, full_rst, clean_rst, hold;
   logic [N_OUT-1:0] oe_block;

   cmc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({rst_pin, pd_oe_pin}),
      .q     (pins_s)
   );

   cmc_pin_decode #(.N_OUT(N_OUT)) u_decode (
      .pd_oe_s         (pins_s[0]),
      .rst_s           (pins_s[1]),
      .cfg_pin_is_oe   (cfg_pin_is_oe),
      .cfg_clean_start (cfg_clean_start),
      .cfg_oe_sens     (cfg_oe_sens),
      .pd_active       (pd_active),
      .full_rst        (full_rst),
      .clean_rst       (clean_rst),
      .oe_block        (oe_block)
   );

   cmc_restart_seq #(.DLY_W(DLY_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clean_en  (cfg_clean_start),
      .clean_rst (clean_rst),
      .lock_dly  (cfg_lock_dly),
      .hold      (hold)
   );

   cmc_out_stage #(.N_OUT(N_OUT)) u_out (
      .clk           (clk),
      .rst_n         (rst_n),
      .pd_active     (pd_active),
      .full_rst      (full_rst),
      .hold          (hold),
      .keep_alive    (cfg_keep_alive),
      .oe_block      (oe_block),
      .pll_en        (pll_en),
      .out_en        (out_en),
      .out_force_low (out_force_low),
      .cfg_restore   (cfg_restore),
      .regs_retain   (regs_retain)
   );
endmodule

// File: tb/clk_mode_ctrl_tb.sv
module clk_mode_ctrl_tb;
   localparam int N  = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pd_oe_pin = 1'b1, rst_pin = 1'b0;
   logic          cfg_pin_is_oe = 1'b0, cfg_keep_alive = 1'b0, cfg_clean_start = 1'b0;
   logic [N-1:0]  cfg_oe_sens = '0;
   logic [DW-1:0] cfg_lock_dly = '0;
   logic          pll_en, cfg_restore, regs_retain;
   logic [N-1:0]  out_en, out_force_low;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clk_mode_ctrl #(.N_OUT(N), .DLY_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pd_oe_pin(pd_oe_pin), .rst_pin(rst_pin),
      .cfg_pin_is_oe(cfg_pin_is_oe), .cfg_keep_alive(cfg_keep_alive),
      .cfg_clean_start(cfg_clean_start), .cfg_oe_sens(cfg_oe_sens),
      .cfg_lock_dly(cfg_lock_dly), .pll_en(pll_en), .out_en(out_en),
      .out_force_low(out_force_low), .cfg_restore(cfg_restore),
      .regs_retain(regs_retain)
   );

   // [19:16] req  [15] is_oe [14] keep [13] clean [12] pd [11] rst [10:7] sens
   // [6] exp pll  [5:2] exp out_en  [1] exp restore  [0] exp retain
   localparam int NV = 12;
   localparam logic [19:0] VEC [NV] = '{
      {4'd3, 1'b0,1'b0,1'b0,1'b1,1'b0,4'b0000, 1'b1,4'b1111,1'b0,1'b0}, // R3 running
      {4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000, 1'b0,4'b0000,1'b1,1'b0}, // R5 drop config
      {4'd4, 1'b0,1'b1,1'b0,1'b0,1'b0,4'b0000, 1'b0,4'b0000,1'b0,1'b1}, // R4 keep-alive
      {4'd5, 1'b0,1'b1,1'b0,1'b1,1'b0,4'b0000, 1'b1,4'b1111,1'b0,1'b0}, // R5 resume
      {4'd6, 1'b1,1'b0,1'b0,1'b0,1'b0,4'b1010, 1'b1,4'b0101,1'b0,1'b0}, // R6
      {4'd6, 1'b1,1'b0,1'b0,1'b0,1'b0,4'b0011, 1'b1,4'b1100,1'b0,1'b0}, // R6
      {4'd7, 1'b1,1'b0,1'b0,1'b1,1'b0,4'b1111, 1'b1,4'b1111,1'b0,1'b0}, // R7
      {4'd6, 1'b1,1'b0,1'b0,1'b0,1'b0,4'b1111, 1'b1,4'b0000,1'b0,1'b0}, // R6 all sensitive
      {4'd8, 1'b0,1'b0,1'b0,1'b1,1'b1,4'b0000, 1'b0,4'b0000,1'b1,1'b0}, // R8 restore
      {4'd8, 1'b0,1'b0,1'b0,1'b1,1'b0,4'b0000, 1'b1,4'b1111,1'b0,1'b0}, // R8 release
      {4'd6, 1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000, 1'b1,4'b1111,1'b0,1'b0}, // R6 keep has no effect
      {4'd8, 1'b1,1'b0,1'b0,1'b1,1'b1,4'b1111, 1'b0,4'b0000,1'b1,1'b0}  // R8 in enable mode
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic r11_chk();
      chk("R11 force_low", {28'd0, out_force_low}, {28'd0, ~out_en});
   endtask

   task automatic clean_release(input int d, input string tag);
      rst_pin = 1'b0;
      edges(d + 4);
      chk(tag, {28'd0, out_en}, 32'h0);
      edges(1);
      chk(tag, {28'd0, out_en}, 32'hF);
      r11_chk();
   endtask

   initial begin
      @(negedge clk);
      edges(2);
      // R1: reset state
      chk("R1 pll_en", {31'd0, pll_en}, 32'd0);
      chk("R1 out_en", {28'd0, out_en}, 32'h0);
      chk("R1 force_low", {28'd0, out_force_low}, 32'hF);
      chk("R1 restore/retain", {30'd0, cfg_restore, regs_retain}, 32'd0);
      rst_n = 1'b1;
      edges(4);

      for (int v = 0; v < NV; v++) begin
         cfg_pin_is_oe   = VEC[v][15];
         cfg_keep_alive  = VEC[v][14];
         cfg_clean_start = VEC[v][13];
         pd_oe_pin       = VEC[v][12];
         rst_pin         = VEC[v][11];
         cfg_oe_sens     = VEC[v][10:7];
         edges(4);
         chk($sformatf("R%0d vec%0d pll_en", VEC[v][19:16], v), {31'd0, pll_en}, {31'd0, VEC[v][6]});
         chk($sformatf("R%0d vec%0d out_en", VEC[v][19:16], v), {28'd0, out_en}, {28'd0, VEC[v][5:2]});
         chk($sformatf("R%0d vec%0d flags", VEC[v][19:16], v), {30'd0, cfg_restore, regs_retain},
             {30'd0, VEC[v][1:0]});
         r11_chk();
      end

      // R2: latency of the pin path
      cfg_pin_is_oe = 1'b0; cfg_keep_alive = 1'b0; cfg_clean_start = 1'b0;
      pd_oe_pin = 1'b1; rst_pin = 1'b0; cfg_oe_sens = '0;
      edges(4);
      pd_oe_pin = 1'b0;
      edges(2);
      chk("R2 unchanged after 2 edges", {31'd0, pll_en}, 32'd1);
      edges(1);
      chk("R2 changed on 3rd edge", {31'd0, pll_en}, 32'd0);
      pd_oe_pin = 1'b1;
      edges(4);

      // R9 / R10: clean start with D = 3
      cfg_clean_start = 1'b1; cfg_lock_dly = 8'd3;
      edges(1);
      rst_pin = 1'b1;
      edges(3);
      chk("R9 outputs off", {28'd0, out_en}, 32'h0);
      chk("R9 pll stays on, no restore", {30'd0, pll_en, cfg_restore}, 32'd2);
      r11_chk();
      edges(5);
      clean_release(3, "R10 D=3");

      // R10 with D = 0
      cfg_lock_dly = 8'd0;
      rst_pin = 1'b1;
      edges(6);
      clean_release(0, "R10 D=0");

      // R12: reset returns during the lock wait (D = 6)
      cfg_lock_dly = 8'd6;
      rst_pin = 1'b1;
      edges(6);
      rst_pin = 1'b0;
      edges(4);
      rst_pin = 1'b1;
      edges(12);
      chk("R12 still off after re-hold", {28'd0, out_en}, 32'h0);
      clean_release(6, "R12 fresh count");

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule